// File: doc/BRIEF.md
# Disk Rotation Position Tracker

This block models where a head-per-track disk is in its spin. A word-position counter moves forward by one word after each programmable interval of clock cycles. It wraps back to zero after one track's worth of words. An index bit marks a short window of words just after the wrap point. Two combinational outputs compare a requested disk address with the present position. One says whether the two are equal. The other gives how many words the rotation still has to travel to reach the address.

A transfer engine asks for a word by pulsing a request strobe while it drives the address. The tracker keeps the low position bits of that address as its target. It gives one start strobe when the rotation next steps onto the target word. If the target is the word under the head at the time of the request, the start comes one full revolution later. Only the position bits of the requested address take part. Higher bits belong to the caller and are ignored.

Top module: `rot_tracker`

## Requirements
- R1: While reset is asserted (rst_n low) and right after it, the position reads 0 and start_pulse is low. No request is pending.
- R2: The position rises by exactly 1 every L clock cycles, where L is interval_len. An interval_len of 0 behaves as 1, so the position moves on every cycle.
- R3: From the last word, 2047, the position steps to 0.
- R4: index_mark is 1 while the position is below 6 and 0 from position 6 through 2047.
- R5: addr_match is 1 exactly when req_addr[10:0] equals the position. req_addr[11] has no effect.
- R6: lead_words equals (req_addr[10:0] − position) modulo 2048.
- R7: A request is sampled on a clock edge with req_valid high. Call the lead at that time d, or 2048 when d is 0. start_pulse is then high for one cycle. It comes in the cycle where the position first equals the target, after exactly d advances counted from the request edge, that edge included.
- R8: Each request gives at most one start_pulse. With no pending request, start_pulse stays low.
- R9: A new request while one is pending replaces the target. The old target then gives no start_pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| interval_len | input | 16 | Clock cycles per word position (0 acts as 1) |
| req_addr | input | 12 | Requested disk address; the low 11 bits select the word |
| req_valid | input | 1 | One-cycle request strobe |
| pos | output | 11 | Current word position |
| index_mark | output | 1 | High while the position lies in the index window |
| addr_match | output | 1 | Requested word is under the head now |
| lead_words | output | 11 | Words remaining until the requested word |
| start_pulse | output | 1 | One-cycle strobe when the rotation reaches the target |

## Verification
A prescaler count that goes wrong shows up as a spacing other than interval_len between position changes. This appears within one interval. A position counter fault appears at once in lead_words and addr_match for any fixed address. A bad wrap shows up when 2047 is passed, and a bad index window shows up within the first few words after 0. A fault in the stored target or the pending flag stays hidden until the next start strobe. So each case is followed up to one full revolution, and the number of advances before the strobe is checked.

// File: rtl/rot_pkg.sv
package rot_pkg;
    localparam int TRACK_WORDS_DEF = 2048;
    localparam int INDEX_WIN_DEF   = 6;
    localparam int IVAL_W_DEF      = 16;
    localparam int ADDR_W_DEF      = 12;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_WAIT = 1'b1
    } arm_state_e;
endpackage

// File: rtl/rot_tick_gen.sv
module rot_tick_gen #(
    parameter int IVAL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVAL_W-1:0] interval_len,
    output logic              tick
);
    typedef struct packed {
        logic [IVAL_W-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;
    logic     last_c;

    always_comb begin
        st_d   = st_q;
        last_c = (interval_len == '0) ||
                 (st_q.cnt >= IVAL_W'(interval_len - 1'b1));
        if (last_c) st_d.cnt = '0;
        else        st_d.cnt = st_q.cnt + 1'b1;
    end

    assign tick = last_c;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rot_pos_ctr.sv
module rot_pos_ctr #(
    parameter int TRACK_WORDS = 2048,
    localparam int POS_W = $clog2(TRACK_WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pos_next
);
    typedef struct packed {
        logic [POS_W-1:0] pos;
    } pos_st_t;

    pos_st_t st_d, st_q;

    generate
        if ((1 << POS_W) == TRACK_WORDS) begin : g_pow2
            assign pos_next = st_q.pos + 1'b1;
        end else begin : g_cmp
            assign pos_next = (st_q.pos == POS_W'(TRACK_WORDS - 1)) ? '0
                                                                    : st_q.pos + 1'b1;
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (tick) st_d.pos = pos_next;
    end

    assign pos = st_q.pos;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rot_start_arm.sv
module rot_start_arm
    import rot_pkg::*;
#(
    parameter int POS_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [POS_W-1:0] pos_next,
    input  logic             req_valid,
    input  logic [POS_W-1:0] req_word,
    output logic             start_pulse
);
    typedef struct packed {
        arm_state_e       state;
        logic [POS_W-1:0] target;
        logic             start;
    } arm_st_t;

    arm_st_t          st_d, st_q;
    logic             armed_c;
    logic [POS_W-1:0] goal_c;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        armed_c    = req_valid || (st_q.state == ARM_WAIT);
        goal_c     = req_valid ? req_word : st_q.target;
        if (req_valid) begin
            st_d.state  = ARM_WAIT;
            st_d.target = req_word;
        end
        if (armed_c && tick && (pos_next == goal_c)) begin
            st_d.start = 1'b1;
            st_d.state = ARM_IDLE;
        end
    end

    assign start_pulse = st_q.start;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state  <= ARM_IDLE;
            st_q.target <= '0;
            st_q.start  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rot_tracker.sv
module rot_tracker
    import rot_pkg::*;
#(
    parameter int TRACK_WORDS = TRACK_WORDS_DEF,
    parameter int INDEX_WIN   = INDEX_WIN_DEF,
    parameter int IVAL_W      = IVAL_W_DEF,
    parameter int ADDR_W      = ADDR_W_DEF,
    localparam int POS_W = $clog2(TRACK_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IVAL_W-1:0] interval_len,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_valid,
    output logic [POS_W-1:0]  pos,
    output logic              index_mark,
    output logic              addr_match,
    output logic [POS_W-1:0]  lead_words,
    output logic              start_pulse
);
    logic             tick;
    logic [POS_W-1:0] pos_next;
    logic [POS_W-1:0] req_word;

    assign req_word = req_addr[POS_W-1:0];

    rot_tick_gen #(.IVAL_W(IVAL_W)) u_tick (
        .clk          (clk),
        .rst_n        (rst_n),
        .interval_len (interval_len),
        .tick         (tick)
    );

    rot_pos_ctr #(.TRACK_WORDS(TRACK_WORDS)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .pos      (pos),
        .pos_next (pos_next)
    );

    rot_start_arm #(.POS_W(POS_W)) u_arm (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .pos_next    (pos_next),
        .req_valid   (req_valid),
        .req_word    (req_word),
        .start_pulse (start_pulse)
    );

    always_comb begin
        index_mark = (pos < POS_W'(INDEX_WIN));
        addr_match = (req_word == pos);
        if (req_word >= pos) lead_words = req_word - pos;
        else                 lead_words = POS_W'(TRACK_WORDS) + req_word - pos;
    end
endmodule

// File: rtl/rot_tracker_chk.sv
module rot_tracker_chk #(
    parameter int TRACK_WORDS = 2048,
    parameter int INDEX_WIN   = 6,
    parameter int POS_W       = 11
) (
    input logic             clk,
    input logic             rst_n,
    input logic [POS_W-1:0] pos,
    input logic             index_mark,
    input logic             start_pulse
);
    localparam logic [POS_W-1:0] LAST = POS_W'(TRACK_WORDS - 1);

    // R1
    reset_home_chk: assert property (@(posedge clk)
        !rst_n |=> (pos == '0 && !start_pulse));

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos) && $past(pos) != LAST) |-> (pos == $past(pos) + 1'b1));

    // R3
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos != $past(pos) && $past(pos) == LAST) |-> (pos == '0));

    // R4
    index_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(index_mark) |-> (pos == '0));

    // R4
    index_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(index_mark) |-> (pos == POS_W'(INDEX_WIN)));

    // R7
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);

    // R7
    pulse_on_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (pos != $past(pos)));
endmodule

bind rot_tracker rot_tracker_chk #(
    .TRACK_WORDS (TRACK_WORDS),
    .INDEX_WIN   (INDEX_WIN),
    .POS_W       (POS_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pos         (pos),
    .index_mark  (index_mark),
    .start_pulse (start_pulse)
);

// File: tb/sim_rot_tracker.sv
module sim_rot_tracker;
    localparam int TRACK = 2048;
    localparam int MASK  = TRACK - 1;
    localparam int NVEC  = 6;
    // fields: interval[27:24], address[23:12], advances to skip first[11:0]
    localparam logic [27:0] VEC [NVEC] = '{
        {4'd1, 12'h010, 12'd3},
        {4'd2, 12'hFFF, 12'd0},
        {4'd1, 12'h805, 12'd7},
        {4'd4, 12'h003, 12'd1},
        {4'd0, 12'h100, 12'd2},
        {4'd3, 12'h7F0, 12'd5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] interval_len = 16'd1;
    logic [11:0] req_addr = '0;
    logic        req_valid = 1'b0;
    logic [10:0] pos;
    logic        index_mark, addr_match, start_pulse;
    logic [10:0] lead_words;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    bit adv;
    int prev_pos = 0;

    always #4 clk = ~clk;

    rot_tracker u0 (
        .clk(clk), .rst_n(rst_n), .interval_len(interval_len),
        .req_addr(req_addr), .req_valid(req_valid), .pos(pos),
        .index_mark(index_mark), .addr_match(addr_match),
        .lead_words(lead_words), .start_pulse(start_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        adv = (int'(pos) != prev_pos);
        prev_pos = int'(pos);
    endtask

    task automatic skip_adv(input int n);
        int k = 0;
        while (k < n) begin
            step();
            if (adv) k++;
        end
    endtask

    // issue a request at the current negedge and follow it to its start strobe
    task automatic run_req(input logic [11:0] addr, input string tag);
        int p = int'(pos);
        int t = int'(addr) & MASK;
        int ld = (t - p) & MASK;
        int dexp = (ld == 0) ? TRACK : ld;
        int n = 0;
        bit got = 1'b0;
        req_addr = addr;
        #1;
        chk(int'(lead_words) == ld, "R6", int'(lead_words), ld);
        chk(addr_match == (ld == 0), "R5", int'(addr_match), int'(ld == 0));
        req_valid = 1'b1;
        while (!got && n <= TRACK + 2) begin
            step();
            req_valid = 1'b0;
            if (adv) n++;
            if (start_pulse) got = 1'b1;
        end
        chk(got && n == dexp, {"R7 advances ", tag}, n, dexp);
        chk(int'(pos) == t, {"R7 position ", tag}, int'(pos), t);
        step();
        chk(start_pulse == 1'b0, {"R7 width ", tag}, int'(start_pulse), 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int spacing;
        int pulses;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(pos == 11'd0, "R1 pos", int'(pos), 0);
        chk(start_pulse == 1'b0, "R1 start", int'(start_pulse), 0);
        chk(index_mark == 1'b1, "R4 index at reset", int'(index_mark), 1);
        rst_n = 1'b1;
        prev_pos = 0;

        // R3 R4 R8: a full revolution with interval 1 and no request
        pulses = 0;
        for (int i = 0; i < TRACK + 4; i++) begin
            step();
            if (start_pulse) pulses++;
            if (adv) begin
                chk(index_mark == (int'(pos) < 6), "R4 window", int'(index_mark), int'(int'(pos) < 6));
                if (int'(pos) == 0)
                    chk(1'b1, "R3 wrap", 0, 0);
            end
        end
        chk(pulses == 0, "R8 idle no pulse", pulses, 0);

        // R2 spacing for several intervals, 0 acts as 1
        for (int L = 0; L < 6; L++) begin
            interval_len = 16'(L);
            skip_adv(2);
            spacing = 0;
            do begin
                step();
                spacing++;
            end while (!adv);
            chk(spacing == ((L == 0) ? 1 : L), "R2 spacing", spacing, (L == 0) ? 1 : L);
        end

        // R5: match sees only the low bits
        interval_len = 16'd8;
        skip_adv(1);
        req_addr = {1'b1, pos};
        #1;
        chk(addr_match == 1'b1, "R5 high bit ignored", int'(addr_match), 1);
        req_addr = {1'b0, pos + 11'd1};
        #1;
        chk(addr_match == 1'b0, "R5 mismatch", int'(addr_match), 0);

        // R6 R7: vector table
        for (int v = 0; v < NVEC; v++) begin
            interval_len = 16'(VEC[v][27:24]);
            skip_adv(int'(VEC[v][11:0]));
            run_req(VEC[v][23:12], $sformatf("vec%0d", v));
        end

        // R7: target equal to the current word waits a full revolution
        interval_len = 16'd5;
        skip_adv(1);
        run_req({1'b0, pos}, "same word");

        // R3: a target just past the wrap point
        interval_len = 16'd1;
        run_req(12'd2, "across wrap");

        // R9 and R8: a new request replaces a pending one
        interval_len = 16'd1;
        skip_adv(1);
        req_addr = 12'((int'(pos) + 600) & MASK);
        req_valid = 1'b1;
        step();
        req_valid = 1'b0;
        repeat (5) step();
        run_req(12'((int'(pos) + 20) & MASK), "R9 replace");
        pulses = 0;
        for (int i = 0; i < 700; i++) begin
            step();
            if (start_pulse) pulses++;
        end
        chk(pulses == 0, "R9 old target dropped", pulses, 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule